// File: doc/BRIEF.md
# Two-Channel Memory/I-O Transfer Engine

This block moves data between memory and I/O spaces on its own, without the CPU taking part. It has two channels. Each channel holds a 20-bit source pointer, a 20-bit destination pointer, a 16-bit transfer counter and a control word. Software loads these through a small register port and reads them back through the same port. A channel asks for service when its start bit is set and its chosen request source is high. That source is either the channel's own external request pin or a shared timer request line.

The engine serves one channel at a time on a simple bus master port. Every transfer is a read from the source address followed by a write of the captured data to the destination address. Nothing else can use the bus between those two cycles. Each bus cycle lasts until the bus answers with ready. After the write, one shared 20-bit adder/subtractor steps the source pointer and then the destination pointer. The counter then decrements. In terminal-count mode the channel stops when its counter reaches zero, and it can raise an interrupt.

Requests are level-sensitive and are sampled only while the engine is idle, between transfers. When both channels ask together, a per-channel priority bit decides the winner. With equal priority bits, the channels take turns.

Top module: `dma2ch`

## Requirements
- R1: Register address bit 4 selects the channel (0 or 1). Low nibble offsets: 0h control, 2h counter, 4h source low, 6h source high, 8h destination low, Ah destination high. A high-half register stores and returns only pointer bits 19:16, in data bits 3:0, and reads 0 above them. Every register reads back what was written, and all registers reset to 0.
- R2: Control bit 4 selects the request source: 1 uses `tmr_req`, 0 uses the channel's `drq` bit. The source that is not selected has no effect. A channel with control bit 0 (start) clear issues no transfer.
- R3: A transfer reads from the source pointer, with `bus_io` set to control bit 5. It then writes the captured read data unchanged to the destination pointer, with `bus_io` set to control bit 6. Control bit 1 drives `bus_word` (1 means word, 0 means byte).
- R4: `bus_rd` and `bus_wr` stay asserted, with a stable address, until `bus_ready` is sampled high.
- R5: After each transfer the source pointer changes by the mode in control bits 8:7, and the destination pointer by the mode in bits 10:9: 00 hold, 01 increment, 10 decrement. The step is 2 for a word and 1 for a byte. The carry propagates across all 20 bits.
- R6: The counter decrements by one per transfer. With control bit 2 (terminal count) set, the transfer that brings the counter to 0 clears the start bit, so no further transfer follows.
- R7: When the start bit is cleared by terminal count and control bit 3 is set, `irq` for that channel rises and stays high. Any write to that channel's control register clears it.
- R8: With control bit 2 clear, the counter wraps from 0 to FFFFh and the start bit stays set.
- R9: If both channels request and exactly one has control bit 11 (priority) set, that channel is served first.
- R10: If both channels request with equal priority bits, the channel that was not served most recently is served. After reset, channel 0 wins.
- R11: A read cycle is always followed directly by its write cycle. Arbitration happens only between complete transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (bit 4 is the channel, bits 3:0 the offset) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| drq | input | 2 | External request pin per channel |
| tmr_req | input | 1 | Timer request shared by both channels |
| bus_addr | output | 20 | Bus address |
| bus_io | output | 1 | 1 selects I/O space, 0 selects memory |
| bus_word | output | 1 | 1 selects a word transfer, 0 a byte transfer |
| bus_rd | output | 1 | Read cycle active |
| bus_wr | output | 1 | Write cycle active |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Current bus cycle completes this clock |
| irq | output | 2 | Terminal-count interrupt per channel |

## Verification
A wrong pointer or adder result shows up on `bus_addr` in the very next transfer of that channel, and in the readback of the pointer registers. A counter or terminal-count fault shows up as one transfer too many or too few, or as a start bit or interrupt in the wrong state, a few cycles after the last write. A faulty arbiter or last-served state shows up in the order of the destination addresses that the bench logs. A broken read/write pairing shows up in the same bus cycle as a write without a read before it.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  localparam int CTRL_W  = 12;
  localparam int B_START = 0;
  localparam int B_WORD  = 1;
  localparam int B_TC    = 2;
  localparam int B_IRQ   = 3;
  localparam int B_TSEL  = 4;
  localparam int B_SIO   = 5;
  localparam int B_DIO   = 6;
  localparam int B_SMODE = 7;
  localparam int B_DMODE = 9;
  localparam int B_PRIO  = 11;

  localparam logic [3:0] OFF_CTRL   = 4'h0;
  localparam logic [3:0] OFF_CNT    = 4'h2;
  localparam logic [3:0] OFF_SRC_LO = 4'h4;
  localparam logic [3:0] OFF_SRC_HI = 4'h6;
  localparam logic [3:0] OFF_DST_LO = 4'h8;
  localparam logic [3:0] OFF_DST_HI = 4'hA;

  localparam logic [1:0] MODE_INC = 2'b01;
  localparam logic [1:0] MODE_DEC = 2'b10;

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WR, ST_USRC, ST_UDST} xfer_st_t;
endpackage

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int PTR_W = 20,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_off,
  input  logic [15:0]       wr_data,
  input  logic              ld_src,
  input  logic              ld_dst,
  input  logic              ld_cnt,
  input  logic [PTR_W-1:0]  nxt_ptr,
  output logic [PTR_W-1:0]  src_q,
  output logic [PTR_W-1:0]  dst_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              irq_q,
  output logic [15:0]       rd_data
);
  localparam int HI_W = PTR_W - 16;

  logic [PTR_W-1:0]  src_d, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic              irq_d;
  logic              en;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    ctrl_d = ctrl_q;
    irq_d  = irq_q;
    if (wr_en) begin
      case (wr_off)
        OFF_CTRL:   begin ctrl_d = wr_data[CTRL_W-1:0]; irq_d = 1'b0; end
        OFF_CNT:    cnt_d = wr_data[CNT_W-1:0];
        OFF_SRC_LO: src_d[15:0] = wr_data;
        OFF_SRC_HI: src_d[PTR_W-1:16] = wr_data[HI_W-1:0];
        OFF_DST_LO: dst_d[15:0] = wr_data;
        OFF_DST_HI: dst_d[PTR_W-1:16] = wr_data[HI_W-1:0];
        default: ;
      endcase
    end
    if (ld_src) src_d = nxt_ptr;
    if (ld_dst) dst_d = nxt_ptr;
    if (ld_cnt) begin
      cnt_d = cnt_q - 1'b1;
      if (ctrl_q[B_TC] && (cnt_d == '0)) begin
        ctrl_d[B_START] = 1'b0;
        if (ctrl_q[B_IRQ]) irq_d = 1'b1;
      end
    end
  end

  assign en = wr_en | ld_src | ld_dst | ld_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else if (en) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      ctrl_q <= ctrl_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    case (wr_off)
      OFF_CTRL:   rd_data = 16'(ctrl_q);
      OFF_CNT:    rd_data = 16'(cnt_q);
      OFF_SRC_LO: rd_data = src_q[15:0];
      OFF_SRC_HI: rd_data = 16'(src_q[PTR_W-1:16]);
      OFF_DST_LO: rd_data = dst_q[15:0];
      OFF_DST_HI: rd_data = 16'(dst_q[PTR_W-1:16]);
      default:    rd_data = 16'h0000;
    endcase
  end

  // R6: a terminal-count transfer reaching zero stops the channel
  a_r6_tc_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cnt && !wr_en && ctrl_q[B_TC] && (cnt_q == CNT_W'(1))) |=> !ctrl_q[B_START]);

  // R7: the interrupt only rises as the result of a counted transfer
  a_r7_irq_from_tc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(ld_cnt));
endmodule

// File: rtl/dma2ch_arb.sv
module dma2ch_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic [1:0] hi,
  input  logic       take,
  output logic [1:0] gnt
);
  logic last_q, last_d;

  always_comb begin
    if (req == 2'b11) begin
      if (hi[0] != hi[1]) gnt = hi[1] ? 2'b10 : 2'b01;
      else                gnt = last_q ? 2'b01 : 2'b10;
    end else begin
      gnt = req;
    end
  end

  assign last_d = gnt[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= 1'b1;
    else if (take) last_q <= last_d;
  end

  // R9, R10: at most one grant, and only to a requesting channel
  a_r9_grant_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == 2'b00));
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int PTR_W = 20,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [4:0]       reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic [1:0]       drq,
  input  logic             tmr_req,
  output logic [PTR_W-1:0] bus_addr,
  output logic             bus_io,
  output logic             bus_word,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [15:0]      bus_wdata,
  input  logic [15:0]      bus_rdata,
  input  logic             bus_ready,
  output logic [1:0]       irq
);
  localparam int NCH = 2;

  logic [1:0]        rst_q;
  logic              rst_s;
  xfer_st_t          st_q, st_d;
  logic              act_q, act_d;
  logic [15:0]       data_q, data_d;
  logic              take;
  logic [NCH-1:0]    req, hi, gnt;
  logic [PTR_W-1:0]  src_w [NCH];
  logic [PTR_W-1:0]  dst_w [NCH];
  logic [CTRL_W-1:0] ctrl_w [NCH];
  logic [15:0]       rd_w [NCH];
  logic [PTR_W-1:0]  opnd, step, nxt_ptr;
  logic [1:0]        mode;
  logic              dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma2ch_chan #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_s),
      .wr_en   (reg_wr && (reg_addr[4] == 1'(i))),
      .wr_off  (reg_addr[3:0]),
      .wr_data (reg_wdata),
      .ld_src  ((st_q == ST_USRC) && (act_q == 1'(i))),
      .ld_dst  ((st_q == ST_UDST) && (act_q == 1'(i))),
      .ld_cnt  ((st_q == ST_UDST) && (act_q == 1'(i))),
      .nxt_ptr (nxt_ptr),
      .src_q   (src_w[i]),
      .dst_q   (dst_w[i]),
      .ctrl_q  (ctrl_w[i]),
      .irq_q   (irq[i]),
      .rd_data (rd_w[i])
    );
    assign req[i] = ctrl_w[i][B_START] & (ctrl_w[i][B_TSEL] ? tmr_req : drq[i]);
    assign hi[i]  = ctrl_w[i][B_PRIO];
  end

  dma2ch_arb u_arb (
    .clk   (clk),
    .rst_n (rst_s),
    .req   (req),
    .hi    (hi),
    .take  (take),
    .gnt   (gnt)
  );

  assign reg_rdata = rd_w[reg_addr[4]];

  // single shared adder/subtractor for both pointer updates
  assign opnd    = (st_q == ST_USRC) ? src_w[act_q] : dst_w[act_q];
  assign mode    = (st_q == ST_USRC) ? ctrl_w[act_q][B_SMODE +: 2] : ctrl_w[act_q][B_DMODE +: 2];
  assign step    = {{(PTR_W-2){1'b0}}, ctrl_w[act_q][B_WORD], ~ctrl_w[act_q][B_WORD]};
  assign dec     = (mode == MODE_DEC);
  assign nxt_ptr = ((mode == MODE_INC) || dec) ? (opnd + (step ^ {PTR_W{dec}}) + PTR_W'(dec)) : opnd;

  always_comb begin
    st_d   = st_q;
    act_d  = act_q;
    data_d = data_q;
    take   = 1'b0;
    case (st_q)
      ST_IDLE: if (|gnt) begin
        take  = 1'b1;
        act_d = gnt[1];
        st_d  = ST_RD;
      end
      ST_RD: if (bus_ready) begin
        data_d = bus_rdata;
        st_d   = ST_WR;
      end
      ST_WR:   if (bus_ready) st_d = ST_USRC;
      ST_USRC: st_d = ST_UDST;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      act_q  <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      data_q <= data_d;
    end
  end

  assign bus_rd    = (st_q == ST_RD);
  assign bus_wr    = (st_q == ST_WR);
  assign bus_addr  = bus_rd ? src_w[act_q] : dst_w[act_q];
  assign bus_io    = bus_rd ? ctrl_w[act_q][B_SIO] : ctrl_w[act_q][B_DIO];
  assign bus_word  = ctrl_w[act_q][B_WORD];
  assign bus_wdata = data_q;

  // R4: a cycle waiting for ready keeps its strobe and address
  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));
  a_r4_wr_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr)));
  // R11: a read cycle is left only into its own write cycle
  a_r11_pair: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(bus_rd) |-> bus_wr);
  // R3: the write carries what the read returned
  a_r3_data: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(bus_wr) |-> (bus_wdata == $past(bus_rdata)));
endmodule

// File: tb/dma2ch_bench.sv
module dma2ch_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [1:0]  drq;
  logic        tmr_req;
  logic [19:0] bus_addr;
  logic        bus_io, bus_word, bus_rd, bus_wr, bus_ready;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  irq;

  logic [15:0] mem_m [64];
  logic [15:0] io_m  [64];
  logic [19:0] log_addr [64];
  logic        log_io   [64];
  logic [15:0] log_data [64];
  int nwr = 0;
  int pair_err = 0;
  bit rd_pend = 0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma2ch u_dma2ch (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drq(drq), .tmr_req(tmr_req),
    .bus_addr(bus_addr), .bus_io(bus_io), .bus_word(bus_word), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq(irq)
  );

  assign bus_rdata = bus_io ? io_m[bus_addr[5:0]] : mem_m[bus_addr[5:0]];

  always @(negedge clk) begin
    if (bus_rd && bus_ready) begin
      if (rd_pend) pair_err++;
      rd_pend = 1;
    end
    if (bus_wr && bus_ready) begin
      if (!rd_pend) pair_err++;
      rd_pend = 0;
      if (nwr < 64) begin
        log_addr[nwr] = bus_addr;
        log_io[nwr]   = bus_io;
        log_data[nwr] = bus_wdata;
      end
      nwr++;
      if (bus_io) io_m[bus_addr[5:0]] = bus_wdata;
      else if (bus_word) mem_m[bus_addr[5:0]] = bus_wdata;
      else mem_m[bus_addr[5:0]][7:0] = bus_wdata[7:0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int ch, logic [3:0] off, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {1'(ch), off}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, int ch, logic [3:0] off, logic [15:0] exp);
    @(negedge clk);
    reg_addr = {1'(ch), off};
    #1 chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic cfg(int ch, logic [19:0] s, logic [19:0] d, logic [15:0] n, logic [15:0] c);
    wr_reg(ch, 4'h4, s[15:0]); wr_reg(ch, 4'h6, 16'(s[19:16]));
    wr_reg(ch, 4'h8, d[15:0]); wr_reg(ch, 4'hA, 16'(d[19:16]));
    wr_reg(ch, 4'h2, n);       wr_reg(ch, 4'h0, c);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset bus_rd", 32'(bus_rd), 0);
    chk("R1 reset bus_wr", 32'(bus_wr), 0);
    chk("R7 reset irq", 32'(irq), 0);
    rd_chk("R1 reset ctrl0", 0, 4'h0, 16'h0000);
    rd_chk("R1 reset cnt1", 1, 4'h2, 16'h0000);
  endtask

  task automatic t_regs;
    wr_reg(1, 4'h4, 16'hFFFF); wr_reg(1, 4'h6, 16'hFFFF);
    rd_chk("R1 src lo", 1, 4'h4, 16'hFFFF);
    rd_chk("R1 src hi masked", 1, 4'h6, 16'h000F);
    wr_reg(1, 4'hA, 16'h0005);
    rd_chk("R1 dst hi", 1, 4'hA, 16'h0005);
    rd_chk("R1 ch0 untouched", 0, 4'h4, 16'h0000);
  endtask

  task automatic t_basic;
    int b = nwr;
    cfg(0, 20'h00010, 20'h00020, 16'd3, 16'h02CF);
    drq[0] = 1'b1;
    idle(40);
    chk("R6 three transfers", 32'(nwr - b), 3);
    chk("R3 addr0", 32'(log_addr[b]), 32'h20);
    chk("R5 addr1 word step", 32'(log_addr[b+1]), 32'h22);
    chk("R3 data2", 32'(log_data[b+2]), 32'h1014);
    chk("R3 dst io", 32'(log_io[b]), 1);
    rd_chk("R5 src after", 0, 4'h4, 16'h0016);
    rd_chk("R6 cnt zero", 0, 4'h2, 16'h0000);
    rd_chk("R6 start cleared", 0, 4'h0, 16'h02CE);
    chk("R7 irq raised", 32'(irq), 32'h1);
    wr_reg(0, 4'h0, 16'h0000);
    #1 chk("R7 irq cleared", 32'(irq), 0);
    idle(20);
    chk("R2 stopped channel idle", 32'(nwr - b), 3);
    drq[0] = 1'b0;
  endtask

  task automatic t_byte_dec;
    int b = nwr;
    cfg(1, 20'h10001, 20'h00030, 16'd2, 16'h0105);
    drq[1] = 1'b1;
    idle(30);
    drq[1] = 1'b0;
    chk("R6 two byte transfers", 32'(nwr - b), 2);
    chk("R5 dst hold", 32'(log_addr[b+1]), 32'h30);
    chk("R3 byte data", 32'(log_data[b+1]), 32'h1000);
    chk("R3 byte lane", 32'(mem_m[48]), 32'h1000);
    rd_chk("R5 dec borrow lo", 1, 4'h4, 16'hFFFF);
    rd_chk("R5 dec borrow hi", 1, 4'h6, 16'h0000);
    chk("R7 no irq when disabled", 32'(irq), 0);
  endtask

  task automatic t_timer;
    int b = nwr;
    cfg(0, 20'h00008, 20'h00038, 16'd1, 16'h02B7);
    drq[0] = 1'b1; tmr_req = 1'b0;
    idle(20);
    chk("R2 pin ignored", 32'(nwr - b), 0);
    tmr_req = 1'b1;
    idle(20);
    tmr_req = 1'b0; drq[0] = 1'b0;
    chk("R2 timer served", 32'(nwr - b), 1);
    chk("R3 io source data", 32'(log_data[b]), 32'h2008);
    chk("R3 mem dest", 32'(log_io[b]), 0);
  endtask

  task automatic t_prio;
    int b = nwr;
    cfg(0, 20'h00000, 20'h00100, 16'd2, 16'h02C7);
    cfg(1, 20'h00004, 20'h00200, 16'd2, 16'h0AC7);
    drq = 2'b11;
    idle(50);
    drq = 2'b00;
    chk("R9 first", 32'(log_addr[b]), 32'h200);
    chk("R9 second", 32'(log_addr[b+1]), 32'h202);
    chk("R9 third", 32'(log_addr[b+2]), 32'h100);
    chk("R9 fourth", 32'(log_addr[b+3]), 32'h102);
  endtask

  task automatic t_rr;
    int b = nwr;
    cfg(0, 20'h00000, 20'h00100, 16'd2, 16'h02C7);
    cfg(1, 20'h00004, 20'h00200, 16'd2, 16'h02C7);
    drq = 2'b11;
    idle(50);
    drq = 2'b00;
    chk("R10 first", 32'(log_addr[b]), 32'h200);
    chk("R10 second", 32'(log_addr[b+1]), 32'h100);
    chk("R10 third", 32'(log_addr[b+2]), 32'h202);
    chk("R10 fourth", 32'(log_addr[b+3]), 32'h102);
  endtask

  task automatic t_stall;
    int b = nwr;
    cfg(0, 20'h00006, 20'h00300, 16'd1, 16'h02C7);
    bus_ready = 1'b0;
    drq[0] = 1'b1;
    idle(6);
    drq[0] = 1'b0;
    chk("R4 read held", 32'(bus_rd), 1);
    chk("R4 read addr held", 32'(bus_addr), 32'h6);
    bus_ready = 1'b1;
    idle(12);
    chk("R4 one transfer", 32'(nwr - b), 1);
    chk("R4 data", 32'(log_data[b]), 32'h1006);
    chk("R11 read/write pairing", 32'(pair_err), 0);
  endtask

  task automatic t_tc_off;
    int b = nwr;
    cfg(1, 20'h00002, 20'h00310, 16'd0, 16'h02C3);
    drq[1] = 1'b1;
    for (int k = 0; k < 20 && !bus_rd; k++) @(negedge clk);
    drq[1] = 1'b0;
    idle(12);
    chk("R8 one transfer", 32'(nwr - b), 1);
    rd_chk("R8 counter wraps", 1, 4'h2, 16'hFFFF);
    rd_chk("R8 start kept", 1, 4'h0, 16'h02C3);
    wr_reg(1, 4'h0, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_m[i] = 16'h1000 + 16'(i);
      io_m[i]  = 16'h2000 + 16'(i);
    end
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    drq = 2'b00; tmr_req = 1'b0; bus_ready = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_regs;
    t_basic;
    t_byte_dec;
    t_timer;
    t_prio;
    t_rr;
    t_stall;
    t_tc_off;
    chk("R11 pairing overall", 32'(pair_err), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule